// File: doc/BRIEF.md
# Shared Bus Priority Arbiter

This block decides which of five requesters drives a shared system bus. They are an external device, a debug trace master, a descriptor-driven transfer engine, a DMA engine, and the CPU. The CPU owns the bus by default and gets it back whenever no one else is asking. The external device uses a request/acknowledge handshake. The three internal masters each present a request, a burst flag and a protected-phase flag.

Ownership moves only when three things hold together: the current bus cycle is ending, no atomic read-modify-write is in progress, and no split access is in progress. A split access is one that is wider than the addressed memory. Fixed priority picks the next owner, with some exceptions:
- The debug master never cuts into a running burst.
- The DMA engine keeps the bus against the transfer engine while it is in a burst or a protected phase.
- A pending unmasked interrupt raises a reclaim output. The external owner is expected to answer it by dropping its request.

Top module: `bus_arb_top`

## Requirements
- R1: After reset the CPU grant is 1, all other grants are 0, the external acknowledge is 0 and the reclaim output is 0. At no time is more than one of {cpu grant, three master grants, external acknowledge} high.
- R2: An internal owner keeps the bus on any clock edge where cyc_end is 0. All grant outputs are registered and change only on the edge that follows a legal boundary.
- R3: At a legal boundary, the next owner follows this priority: external request, debug (req bit 2), transfer engine (req bit 1), DMA (req bit 0), CPU. The CPU is granted when nothing is requested.
- R4: The debug master is not granted while the current owner is the transfer engine or the DMA engine and that owner's burst flag is set. It is granted at the first legal boundary after the flag clears.
- R5: While the DMA engine owns the bus and keeps requesting with its burst flag or its protected flag (bit 0) set, a transfer-engine request does not take the bus from it.
- R6: When ext_req is high at a legal boundary, ext_ack rises on the next edge and every internal grant is 0. ext_ack stays high while ext_req stays high.
- R7: While ext_ack is high, ext_req sampled low clears ext_ack on the next edge. One edge later the CPU is granted. No grant is high in the cycle between.
- R8: reclaim_o is registered. It is 1 after an edge where irq_pend is 1, irq_lvl is strictly greater than irq_mask (unsigned), and the bus is not passing to the CPU. Otherwise it is 0, which includes the case of equal level and mask.
- R9: While atomic_lock or split_busy is 1, no handover happens, not even to an external request, even when cyc_end is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 3 | Requests: bit0 DMA, bit1 transfer engine, bit2 debug |
| burst | input | 3 | Burst-running flags, same bit order |
| prot | input | 3 | Protected-phase flags, same bit order (bit 0 used) |
| cyc_end | input | 1 | Current bus cycle ends this clock |
| atomic_lock | input | 1 | Atomic read-to-write window in progress |
| split_busy | input | 1 | Multi-part narrow-memory access in progress |
| ext_req | input | 1 | External bus request |
| ext_ack | output | 1 | Bus released to the external device |
| irq_pend | input | 1 | An interrupt is pending |
| irq_lvl | input | LVL_W | Level of the pending interrupt |
| irq_mask | input | LVL_W | Current interrupt mask |
| gnt_cpu | output | 1 | CPU owns the bus |
| gnt | output | 3 | Master grants, same bit order as req |
| reclaim_o | output | 1 | Request that the external owner give the bus back |

## Verification
The bound checker checks these properties on every cycle:
- grant exclusivity
- ownership holding when no legal boundary occurs
- the debug master staying out of a running burst
- the DMA engine keeping the bus in its protected phases
- the acknowledge dropping and the CPU returning after release
- reclaim falling when the interrupt condition is false or the CPU owns the bus

Only the bench scenarios can show the following:
- the full priority order under mixed request patterns
- a debug grant arriving once a burst ends
- the equal-level case of the interrupt compare
- the one-cycle gap with no owner during a return

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NREQ    = 3;
  localparam int IDX_DMA = 0;
  localparam int IDX_XFR = 1;
  localparam int IDX_DBG = 2;

  typedef enum logic [2:0] {
    OWN_CPU = 3'd0,
    OWN_DMA = 3'd1,
    OWN_XFR = 3'd2,
    OWN_DBG = 3'd3,
    OWN_EXT = 3'd4,
    OWN_RET = 3'd5
  } owner_e;

  function automatic logic level_beats_mask(input logic pend,
                                            input logic [7:0] lvl,
                                            input logic [7:0] mask);
    return pend && (lvl > mask);
  endfunction
endpackage

// File: rtl/arb_irq_detect.sv
module arb_irq_detect #(
  parameter int LVL_W = 4
) (
  input  logic             irq_pend,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic [LVL_W-1:0] irq_mask,
  output logic             irq_cond
);
  import arb_pkg::*;
  localparam int PADW = 8 - LVL_W;

  logic [7:0] lvl_ext, mask_ext;

  generate
    if (PADW > 0) begin : g_pad
      assign lvl_ext  = {{PADW{1'b0}}, irq_lvl};
      assign mask_ext = {{PADW{1'b0}}, irq_mask};
    end else begin : g_nopad
      assign lvl_ext  = irq_lvl[7:0];
      assign mask_ext = irq_mask[7:0];
    end
  endgenerate

  assign irq_cond = level_beats_mask(irq_pend, lvl_ext, mask_ext);
endmodule

// File: rtl/arb_pick.sv
module arb_pick (
  input  arb_pkg::owner_e       owner,
  input  logic [arb_pkg::NREQ-1:0] req,
  input  logic [arb_pkg::NREQ-1:0] burst,
  input  logic [arb_pkg::NREQ-1:0] prot,
  input  logic                  ext_req,
  output arb_pkg::owner_e       winner,
  output logic                  dbg_blocked,
  output logic                  dma_keeps
);
  import arb_pkg::*;

  always_comb begin
    dbg_blocked = ((owner == OWN_DMA) && burst[IDX_DMA]) ||
                  ((owner == OWN_XFR) && burst[IDX_XFR]);
    dma_keeps   = (owner == OWN_DMA) && req[IDX_DMA] &&
                  (burst[IDX_DMA] || prot[IDX_DMA]);
    if (ext_req)                            winner = OWN_EXT;
    else if (req[IDX_DBG] && !dbg_blocked)  winner = OWN_DBG;
    else if (dma_keeps)                     winner = OWN_DMA;
    else if (req[IDX_XFR])                  winner = OWN_XFR;
    else if (req[IDX_DMA])                  winner = OWN_DMA;
    else                                    winner = OWN_CPU;
  end
endmodule

// File: rtl/arb_grant_decode.sv
module arb_grant_decode (
  input  arb_pkg::owner_e          owner,
  output logic                     gnt_cpu,
  output logic [arb_pkg::NREQ-1:0] gnt,
  output logic                     ext_ack
);
  import arb_pkg::*;

  assign gnt_cpu      = (owner == OWN_CPU);
  assign gnt[IDX_DMA] = (owner == OWN_DMA);
  assign gnt[IDX_XFR] = (owner == OWN_XFR);
  assign gnt[IDX_DBG] = (owner == OWN_DBG);
  assign ext_ack      = (owner == OWN_EXT);
endmodule

// File: rtl/bus_arb_top.sv
module bus_arb_top #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       req,
  input  logic [2:0]       burst,
  input  logic [2:0]       prot,
  input  logic             cyc_end,
  input  logic             atomic_lock,
  input  logic             split_busy,
  input  logic             ext_req,
  output logic             ext_ack,
  input  logic             irq_pend,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic [LVL_W-1:0] irq_mask,
  output logic             gnt_cpu,
  output logic [2:0]       gnt,
  output logic             reclaim_o
);
  import arb_pkg::*;

  owner_e owner_q, owner_nxt, winner;
  logic   hand_ok;
  logic   irq_cond;
  logic   dbg_blocked;
  logic   dma_keeps;
  logic   reclaim_q;

  assign hand_ok = cyc_end && !atomic_lock && !split_busy;

  arb_pick u_pick (
    .owner       (owner_q),
    .req         (req),
    .burst       (burst),
    .prot        (prot),
    .ext_req     (ext_req),
    .winner      (winner),
    .dbg_blocked (dbg_blocked),
    .dma_keeps   (dma_keeps)
  );

  arb_irq_detect #(.LVL_W(LVL_W)) u_irq (
    .irq_pend (irq_pend),
    .irq_lvl  (irq_lvl),
    .irq_mask (irq_mask),
    .irq_cond (irq_cond)
  );

  always_comb begin
    owner_nxt = owner_q;
    case (owner_q)
      OWN_EXT: if (!ext_req) owner_nxt = OWN_RET;
      OWN_RET: owner_nxt = OWN_CPU;
      default: if (hand_ok) owner_nxt = winner;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q   <= OWN_CPU;
      reclaim_q <= 1'b0;
    end else begin
      owner_q   <= owner_nxt;
      reclaim_q <= irq_cond && (owner_nxt != OWN_CPU);
    end
  end

  arb_grant_decode u_dec (
    .owner   (owner_q),
    .gnt_cpu (gnt_cpu),
    .gnt     (gnt),
    .ext_ack (ext_ack)
  );

  assign reclaim_o = reclaim_q;
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] req,
  input logic [2:0] burst,
  input logic [2:0] prot,
  input logic       ext_req,
  input logic       ext_ack,
  input logic       gnt_cpu,
  input logic [2:0] gnt,
  input logic       reclaim_o,
  input logic       hand_ok,
  input logic       irq_cond
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_cpu, gnt, ext_ack})); // R1

  AST_HOLD_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_cpu || (|gnt)) && !hand_ok) |=> $stable({gnt_cpu, gnt, ext_ack})); // R2

  AST_DBG_NO_BURST_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[1] && burst[1] && req[1] && !ext_req) |=> !gnt[2]); // R4

  AST_DMA_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[0] && req[0] && (burst[0] || prot[0]) && !ext_req) |=> !gnt[1]); // R5

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_ack) |-> $past(ext_req)); // R6

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ack && !ext_req) |=> !ext_ack); // R7

  AST_CPU_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_ack) |=> gnt_cpu); // R7

  AST_RECLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_cond |=> !reclaim_o); // R8

  AST_RECLAIM_NOT_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    reclaim_o |-> !gnt_cpu); // R8
endmodule

bind bus_arb_top bus_arb_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .burst     (burst),
  .prot      (prot),
  .ext_req   (ext_req),
  .ext_ack   (ext_ack),
  .gnt_cpu   (gnt_cpu),
  .gnt       (gnt),
  .reclaim_o (reclaim_o),
  .hand_ok   (hand_ok),
  .irq_cond  (irq_cond)
);

// File: tb/bus_arb_top_bench.sv
module bus_arb_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = '0, burst = '0, prot = '0;
  logic       cyc_end = 1'b1, atomic_lock = 1'b0, split_busy = 1'b0;
  logic       ext_req = 1'b0, irq_pend = 1'b0;
  logic [3:0] irq_lvl = '0, irq_mask = '0;
  logic       ext_ack, gnt_cpu, reclaim_o;
  logic [2:0] gnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // observed vector: {reclaim, ext_ack, dbg, xfer, dma, cpu}
  localparam logic [5:0] E_CPU = 6'b000001, E_DMA = 6'b000010, E_XFR = 6'b000100,
                         E_DBG = 6'b001000, E_EXT = 6'b010000, E_NONE = 6'b000000,
                         E_RCL = 6'b100000;

  typedef struct { logic [5:0] exp; string tag; } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  bus_arb_top u_bus_arb_top (
    .clk(clk), .rst_n(rst_n), .req(req), .burst(burst), .prot(prot),
    .cyc_end(cyc_end), .atomic_lock(atomic_lock), .split_busy(split_busy),
    .ext_req(ext_req), .ext_ack(ext_ack), .irq_pend(irq_pend),
    .irq_lvl(irq_lvl), .irq_mask(irq_mask), .gnt_cpu(gnt_cpu), .gnt(gnt),
    .reclaim_o(reclaim_o)
  );

  // driver: inputs already set for this cycle; push expected result of next edge
  task automatic tick(input logic [5:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // monitor
  always begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      item_t it;
      logic [5:0] act;
      it  = sb.pop_front();
      act = {reclaim_o, ext_ack, gnt[2], gnt[1], gnt[0], gnt_cpu};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0;
    tick(E_CPU, "R1 reset state");
    rst_n = 1'b1;
    tick(E_CPU, "R1 idle after reset");
    // R3 priority
    req = 3'b001;                tick(E_DMA, "R3 dma alone");
    req = 3'b011;                tick(E_XFR, "R3 xfer over dma");
    req = 3'b111;                tick(E_DBG, "R3 debug over all");
    req = 3'b000;                tick(E_CPU, "R3 cpu default");
    // R5 DMA protection, R4 debug vs burst
    req = 3'b001; burst = 3'b001; tick(E_DMA, "R5 dma burst start");
    req = 3'b011;                 tick(E_DMA, "R5 xfer blocked by dma burst");
    req = 3'b111;                 tick(E_DMA, "R4 debug blocked by dma burst");
    req = 3'b011; burst = 3'b000; prot = 3'b001;
                                  tick(E_DMA, "R5 xfer blocked by protected phase");
    prot = 3'b000;                tick(E_XFR, "R3 xfer after protection");
    req = 3'b110; burst = 3'b010; tick(E_XFR, "R4 debug blocked by xfer burst");
    burst = 3'b000;               tick(E_DBG, "R4 debug after burst ends");
    // R2 / R9 boundaries
    req = 3'b010; cyc_end = 1'b0; tick(E_DBG, "R2 hold without cycle end");
    cyc_end = 1'b1; atomic_lock = 1'b1; tick(E_DBG, "R9 atomic lock holds");
    atomic_lock = 1'b0; split_busy = 1'b1; tick(E_DBG, "R9 split access holds");
    ext_req = 1'b1;               tick(E_DBG, "R9 external waits on split");
    split_busy = 1'b0;            tick(E_EXT, "R6 external granted");
    tick(E_EXT, "R6 external held");
    // R8 reclaim
    req = 3'b000; irq_pend = 1'b1; irq_lvl = 4'd5; irq_mask = 4'd5;
    tick(E_EXT, "R8 equal level no reclaim");
    irq_lvl = 4'd6;               tick(E_EXT | E_RCL, "R8 reclaim raised");
    ext_req = 1'b0;               tick(E_NONE | E_RCL, "R7 ack drops gap");
    tick(E_CPU, "R7 cpu returns R8 reclaim clears");
    tick(E_CPU, "R8 no reclaim while cpu owns");
    ext_req = 1'b1;               tick(E_EXT | E_RCL, "R8 reclaim with external owner");
    irq_pend = 1'b0;              tick(E_EXT, "R8 reclaim drops with condition");
    irq_pend = 1'b1; irq_lvl = 4'd15; irq_mask = 4'd15;
    tick(E_EXT, "R8 max equal no reclaim");
    ext_req = 1'b0;               tick(E_NONE, "R7 gap no owner");
    tick(E_CPU, "R7 cpu after gap");
    // R6 external preempts a DMA burst at a boundary
    irq_pend = 1'b0; req = 3'b001; burst = 3'b001; tick(E_DMA, "R5 dma burst again");
    ext_req = 1'b1;               tick(E_EXT, "R6 external over dma burst");
    ext_req = 1'b0; req = 3'b000; burst = 3'b000;
    tick(E_NONE, "R7 release");
    tick(E_CPU, "R7 cpu back");
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule